// File: doc/BRIEF.md
# Windowed Watchdog Reset Generator

This block produces one active-low reset line for an external microcontroller. Both the power-up hold and watchdog faults drive that line. When the supply-good input rises, the line stays asserted for a fixed number of clocks and is then released. Software arms the watchdog by writing 1 to an enable bit. After that it must write 1 again inside a time window. A rewrite that comes too soon is a fault, and so is no rewrite before the limit. Either fault drives a fixed-length reset pulse on the same line.

A boot flag records whether the most recent reset came from the watchdog (warm) or from power-up (cold). Reading the flag clears it. A synchronous hard clear resets all watchdog state and never asserts the reset line. The pad is open-drain and is not part of this block, so the block supplies an output-enable that is the inverse of the reset level.

Timing terms: the arming or refresh write happens on clock edge E0. A later write on edge E0+k has distance k.

Top module: `wdg_rst_gen`

## Requirements
- R1: While `pwr_ok` is low, `rst_out_n` is 0 and `rst_oe` is 1. After `pwr_ok` rises, `rst_out_n` stays 0 through the first HOLD_CYCLES-1 rising edges. It becomes 1 after edge HOLD_CYCLES. `rst_oe` is always the inverse of `rst_out_n`.
- R2: A write strobe that arrives while `rst_out_n` is 0 is ignored. This covers the power-up hold and a watchdog pulse.
- R3: Writing `wr_bit`=1 while disarmed arms the watchdog, and `wd_armed` reads 1. Writing `wr_bit`=0 disarms it without any reset, whatever the distance.
- R4: While armed, a write of 1 at a distance k with EARLY_MIN <= k <= TIMEOUT_MAX restarts the window and causes no reset.
- R5: While armed, a write of 1 at a distance k < EARLY_MIN is a fault. It starts a reset pulse and disarms the watchdog.
- R6: While armed, if no write arrives, a fault occurs on the edge at distance TIMEOUT_MAX. A write on that same edge takes precedence over the timeout.
- R7: A fault drives `rst_out_n` low starting on the faulting edge, for exactly PULSE_CYCLES clock cycles. Afterwards the watchdog stays disarmed until the next enable write.
- R8: `boot_warm` is 0 after power-up and is set by a fault. It is cleared by the edge that samples `rd_stb`=1. If a fault and a read fall on the same edge, the fault wins.
- R9: `hard_clr` disarms the watchdog, ends any watchdog pulse and clears `boot_warm`. It never drives `rst_out_n` low and does not shorten or restart the power-up hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_ok | input | 1 | Filtered supply-good; low holds the block in reset |
| hard_clr | input | 1 | Synchronous clear of watchdog state and boot flag |
| wr_stb | input | 1 | Strobe for a write to the enable bit |
| wr_bit | input | 1 | Value written to the enable bit |
| rd_stb | input | 1 | Boot-flag read strobe (clears the flag) |
| rst_out_n | output | 1 | Active-low reset level toward the controller |
| rst_oe | output | 1 | Open-drain pull-down enable |
| wd_armed | output | 1 | Current value of the enable bit |
| boot_warm | output | 1 | 1 = last reset came from the watchdog |

## Verification
Two events can fall on the same edge: a refresh write and the timeout, when the write lands exactly at distance TIMEOUT_MAX. The bench provokes this and expects the write to win, with no pulse and the watchdog still armed. It also places a boot-flag read on the edge where a timeout fires and expects the flag to end up set. A behavioural model advances on every edge, and its output levels are compared with the design at every falling clock edge.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic [0:0] {
      WIN_OFF = 1'b0,
      WIN_RUN = 1'b1
   } wdg_win_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/wdg_por_hold.sv
module wdg_por_hold #(
   parameter int unsigned HOLD_CYCLES = 64
) (
   input  logic clk,
   input  logic pwr_ok,
   output logic hold
);
   localparam int unsigned CW = wdg_pkg::cnt_width(HOLD_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!pwr_ok) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hold = !pwr_ok || (cnt_q != LAST);
endmodule

// File: rtl/wdg_window.sv
module wdg_window
   import wdg_pkg::*;
#(
   parameter int unsigned EARLY_MIN   = 8,
   parameter int unsigned TIMEOUT_MAX = 40
) (
   input  logic     clk,
   input  logic     pwr_ok,
   input  logic     hard_clr,
   input  logic     wr_ok,
   input  logic     wr_bit,
   output wdg_win_e state,
   output logic     fault
);
   localparam int unsigned TW = cnt_width(TIMEOUT_MAX);
   localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_MAX);
   localparam logic [TW-1:0] FIRST = TW'(1);

   wdg_win_e      state_q;
   logic [TW-1:0] age_q;
   logic          too_soon;
   logic          early_hit;
   logic          expired;

   generate
      if (EARLY_MIN == 0) begin : g_open_window
         assign too_soon = 1'b0;
      end else begin : g_closed_window
         localparam logic [TW-1:0] EARLY_V = TW'(EARLY_MIN);
         assign too_soon = (age_q < EARLY_V);
      end
   endgenerate

   assign early_hit = (state_q == WIN_RUN) && wr_ok && wr_bit && too_soon;
   assign expired   = (state_q == WIN_RUN) && !wr_ok && (age_q == LIMIT);
   assign fault     = pwr_ok && !hard_clr && (early_hit || expired);

   always_ff @(posedge clk) begin
      if (!pwr_ok || hard_clr) begin
         state_q <= WIN_OFF;
         age_q   <= '0;
      end else if (fault) begin
         state_q <= WIN_OFF;
         age_q   <= '0;
      end else if (wr_ok) begin
         if (wr_bit) begin
            state_q <= WIN_RUN;
            age_q   <= FIRST;
         end else begin
            state_q <= WIN_OFF;
            age_q   <= '0;
         end
      end else if (state_q == WIN_RUN) begin
         age_q <= age_q + 1'b1;
      end
   end

   assign state = state_q;
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
   parameter int unsigned PULSE_CYCLES = 16
) (
   input  logic clk,
   input  logic pwr_ok,
   input  logic hard_clr,
   input  logic fire,
   output logic active
);
   localparam int unsigned CW = wdg_pkg::cnt_width(PULSE_CYCLES);
   localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!pwr_ok || hard_clr) begin
         left_q <= '0;
      end else if (fire) begin
         left_q <= LOAD;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign active = (left_q != '0);
endmodule

// File: rtl/wdg_boot_flag.sv
module wdg_boot_flag (
   input  logic clk,
   input  logic pwr_ok,
   input  logic hard_clr,
   input  logic set_warm,
   input  logic rd_clr,
   output logic warm
);
   logic warm_q;

   always_ff @(posedge clk) begin
      if (!pwr_ok || hard_clr) begin
         warm_q <= 1'b0;
      end else if (set_warm) begin
         warm_q <= 1'b1;
      end else if (rd_clr) begin
         warm_q <= 1'b0;
      end
   end

   assign warm = warm_q;
endmodule

// File: rtl/wdg_rst_gen.sv
module wdg_rst_gen
   import wdg_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES  = 64,
   parameter int unsigned EARLY_MIN    = 8,
   parameter int unsigned TIMEOUT_MAX  = 40,
   parameter int unsigned PULSE_CYCLES = 16
) (
   input  logic clk,
   input  logic pwr_ok,
   input  logic hard_clr,
   input  logic wr_stb,
   input  logic wr_bit,
   input  logic rd_stb,
   output logic rst_out_n,
   output logic rst_oe,
   output logic wd_armed,
   output logic boot_warm
);
   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
      if (TIMEOUT_MAX < 1) begin : g_bad_timeout
         $error("TIMEOUT_MAX must be at least 1");
      end
      if (EARLY_MIN >= TIMEOUT_MAX) begin : g_bad_window
         $error("EARLY_MIN must be below TIMEOUT_MAX");
      end
      if (PULSE_CYCLES < 1) begin : g_bad_pulse
         $error("PULSE_CYCLES must be at least 1");
      end
   endgenerate

   logic     por_hold;
   logic     pulse_on;
   logic     busy;
   logic     wr_ok;
   logic     win_fault;
   wdg_win_e win_state;

   wdg_por_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_por (
      .clk    (clk),
      .pwr_ok (pwr_ok),
      .hold   (por_hold)
   );

   assign busy  = por_hold || pulse_on;
   assign wr_ok = wr_stb && !busy;

   wdg_window #(.EARLY_MIN(EARLY_MIN), .TIMEOUT_MAX(TIMEOUT_MAX)) u_win (
      .clk      (clk),
      .pwr_ok   (pwr_ok),
      .hard_clr (hard_clr),
      .wr_ok    (wr_ok),
      .wr_bit   (wr_bit),
      .state    (win_state),
      .fault    (win_fault)
   );

   wdg_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
      .clk      (clk),
      .pwr_ok   (pwr_ok),
      .hard_clr (hard_clr),
      .fire     (win_fault),
      .active   (pulse_on)
   );

   wdg_boot_flag u_boot (
      .clk      (clk),
      .pwr_ok   (pwr_ok),
      .hard_clr (hard_clr),
      .set_warm (win_fault),
      .rd_clr   (rd_stb),
      .warm     (boot_warm)
   );

   assign rst_out_n = !busy;
   assign rst_oe    = busy;
   assign wd_armed  = (win_state == WIN_RUN);
endmodule

// File: rtl/wdg_rst_gen_chk.sv
module wdg_rst_gen_chk (
   input logic clk,
   input logic pwr_ok,
   input logic hard_clr,
   input logic wr_stb,
   input logic wr_bit,
   input logic rd_stb,
   input logic rst_out_n,
   input logic wd_armed,
   input logic boot_warm,
   input logic fault,
   input logic por_hold
);
   p_nopwr_low_r1: assert property (@(posedge clk)
      !pwr_ok |-> !rst_out_n);

   p_busy_ignores_write_r2: assert property (@(posedge clk) disable iff (!pwr_ok)
      (!rst_out_n && !wd_armed && wr_stb) |=> !wd_armed);

   p_zero_write_disarms_r3: assert property (@(posedge clk) disable iff (!pwr_ok)
      (rst_out_n && wr_stb && !wr_bit) |=> (!wd_armed && rst_out_n));

   p_refresh_keeps_r4: assert property (@(posedge clk) disable iff (!pwr_ok)
      (wd_armed && rst_out_n && wr_stb && wr_bit && !hard_clr && !fault)
      |=> (wd_armed && rst_out_n));

   p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!pwr_ok)
      fault |=> (!rst_out_n && !wd_armed));

   p_fault_warm_r8: assert property (@(posedge clk) disable iff (!pwr_ok)
      fault |=> boot_warm);

   p_read_clears_r8: assert property (@(posedge clk) disable iff (!pwr_ok)
      (rd_stb && !fault) |=> !boot_warm);

   p_clear_quiet_r9: assert property (@(posedge clk) disable iff (!pwr_ok)
      (hard_clr && !por_hold) |=> (rst_out_n && !boot_warm && !wd_armed));
endmodule

bind wdg_rst_gen wdg_rst_gen_chk u_chk (
   .clk       (clk),
   .pwr_ok    (pwr_ok),
   .hard_clr  (hard_clr),
   .wr_stb    (wr_stb),
   .wr_bit    (wr_bit),
   .rd_stb    (rd_stb),
   .rst_out_n (rst_out_n),
   .wd_armed  (wd_armed),
   .boot_warm (boot_warm),
   .fault     (win_fault),
   .por_hold  (por_hold)
);

// File: tb/test_wdg_rst_gen.sv
`timescale 1ns/1ps
module test_wdg_rst_gen;
   localparam int HOLD  = 12;
   localparam int EARLY = 5;
   localparam int TMAX  = 20;
   localparam int PULSE = 7;

   logic clk = 1'b0;
   logic pwr_ok = 1'b0, hard_clr = 1'b0, wr_stb = 1'b0, wr_bit = 1'b0, rd_stb = 1'b0;
   logic rst_out_n, rst_oe, wd_armed, boot_warm;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // model state
   int  m_por = 0, m_age = 0, m_pulse = 0;
   bit  m_armed = 1'b0, m_warm = 1'b0;

   always #10 clk = ~clk;

   wdg_rst_gen #(.HOLD_CYCLES(HOLD), .EARLY_MIN(EARLY), .TIMEOUT_MAX(TMAX),
                 .PULSE_CYCLES(PULSE)) i_wdg_rst_gen (
      .clk(clk), .pwr_ok(pwr_ok), .hard_clr(hard_clr), .wr_stb(wr_stb),
      .wr_bit(wr_bit), .rd_stb(rd_stb), .rst_out_n(rst_out_n), .rst_oe(rst_oe),
      .wd_armed(wd_armed), .boot_warm(boot_warm));

   // behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      bit busy, flt;
      if (!pwr_ok) begin
         m_por = 0; m_armed = 0; m_age = 0; m_pulse = 0; m_warm = 0;
      end else begin
         busy = (m_por < HOLD) || (m_pulse > 0);
         flt  = 0;
         if (hard_clr) begin
            m_armed = 0; m_age = 0; m_pulse = 0; m_warm = 0;
         end else begin
            if (wr_stb && !busy) begin
               if (wr_bit) begin
                  if (m_armed && m_age < EARLY) begin flt = 1; m_armed = 0; end
                  else begin m_armed = 1; m_age = 1; end
               end else m_armed = 0;
            end else if (m_armed) begin
               if (m_age == TMAX) begin flt = 1; m_armed = 0; end
               else m_age++;
            end
            if (flt) m_pulse = PULSE;
            else if (m_pulse > 0) m_pulse--;
            if (flt) m_warm = 1;
            else if (rd_stb) m_warm = 0;
         end
         if (m_por < HOLD) m_por++;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   // compare with the model at every falling edge
   always @(negedge clk) begin
      int exp_n;
      if (!done) begin
         exp_n = (pwr_ok && m_por >= HOLD && m_pulse == 0) ? 1 : 0;
         check("R1 R7 rst_out_n vs model", int'(rst_out_n), exp_n);
         check("R1 rst_oe vs model", int'(rst_oe), 1 - exp_n);
         check("R3 wd_armed vs model", int'(wd_armed), int'(m_armed));
         check("R8 boot_warm vs model", int'(boot_warm), int'(m_warm));
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write(input logic b);
      wr_stb = 1'b1; wr_bit = b;
      tick(1);
      wr_stb = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      int n;
      tick(3);
      check("R1 low without supply", int'(rst_out_n), 0);
      check("R1 oe without supply", int'(rst_oe), 1);

      // power-up hold, with writes attempted during it
      pwr_ok = 1'b1; wr_stb = 1'b1; wr_bit = 1'b1;
      tick(HOLD - 1);
      check("R1 still held", int'(rst_out_n), 0);
      check("R2 write during hold ignored", int'(wd_armed), 0);
      wr_stb = 1'b0;
      tick(1);
      check("R1 released", int'(rst_out_n), 1);
      check("R1 oe released", int'(rst_oe), 0);

      // arm and disarm
      write(1'b1);
      check("R3 armed", int'(wd_armed), 1);
      write(1'b0);
      check("R3 disarmed", int'(wd_armed), 0);
      check("R3 no reset on disarm", int'(rst_out_n), 1);

      // valid refresh at both window ends
      write(1'b1);
      tick(EARLY - 1); write(1'b1);
      check("R4 refresh at early limit", int'(rst_out_n), 1);
      check("R4 still armed", int'(wd_armed), 1);
      tick(TMAX - 1); write(1'b1);
      check("R6 refresh on timeout edge wins", int'(rst_out_n), 1);
      check("R6 armed after late refresh", int'(wd_armed), 1);

      // early refresh
      tick(EARLY - 2); write(1'b1);
      check("R5 early refresh resets", int'(rst_out_n), 0);
      check("R5 disarmed", int'(wd_armed), 0);
      check("R8 warm after fault", int'(boot_warm), 1);
      n = 0;
      while (!rst_out_n && n < 100) begin n++; tick(1); end
      check("R7 pulse length", n, PULSE);
      check("R7 stays disarmed", int'(wd_armed), 0);
      tick(TMAX + 2);
      check("R7 no further pulse", int'(rst_out_n), 1);
      rd_stb = 1'b1; tick(1); rd_stb = 1'b0;
      check("R8 read clears", int'(boot_warm), 0);

      // timeout
      write(1'b1);
      tick(TMAX - 1);
      check("R6 before timeout", int'(rst_out_n), 1);
      tick(1);
      check("R6 timeout resets", int'(rst_out_n), 0);
      write(1'b1);
      check("R2 write during pulse ignored", int'(wd_armed), 0);
      hard_clr = 1'b1; tick(1); hard_clr = 1'b0;
      check("R9 clear ends pulse", int'(rst_out_n), 1);
      check("R9 clear drops warm", int'(boot_warm), 0);

      // clear while armed
      write(1'b1);
      tick(3);
      hard_clr = 1'b1; tick(1); hard_clr = 1'b0;
      check("R9 clear disarms", int'(wd_armed), 0);
      check("R9 clear no reset", int'(rst_out_n), 1);
      tick(TMAX + 2);
      check("R9 no timeout after clear", int'(rst_out_n), 1);

      // read on the timeout edge
      write(1'b1);
      tick(TMAX - 1);
      rd_stb = 1'b1; tick(1); rd_stb = 1'b0;
      check("R8 fault beats read", int'(boot_warm), 1);
      check("R6 timeout with read", int'(rst_out_n), 0);
      tick(PULSE + 2);

      // power loss gives a cold start; clear during hold
      pwr_ok = 1'b0; tick(2);
      check("R8 cold after power loss", int'(boot_warm), 0);
      check("R1 low on power loss", int'(rst_out_n), 0);
      pwr_ok = 1'b1; tick(3);
      hard_clr = 1'b1; tick(1); hard_clr = 1'b0;
      tick(HOLD - 5);
      check("R9 hold not shortened", int'(rst_out_n), 0);
      tick(1);
      check("R9 hold ends on time", int'(rst_out_n), 1);

      tick(2);
      finish_run();
   end
endmodule